// File: doc/BRIEF.md
# Byte-Wide Parallel Flash Command Interpreter

This block models the write-control side of a byte-wide parallel NOR flash as synthesizable logic. A host drives active-low chip-enable, output-enable and write-enable strobes together with an address bus and an 8-bit data bus. The block samples those pins on a system clock. It turns write pulses into latched address/data pairs and walks them through the unlock command sequences. From those sequences it starts byte programming, sector or whole-array erasure, and entry to or exit from an identification mode.

The storage array is a small internal RAM. Program and erase run for a parameterised number of clock cycles. During that time the read path returns status bits in place of array contents: bit 7 works as a completion flag and bit 6 alternates on every read. In identification mode, reads of the two lowest addresses return the maker and device codes.

Top module: `nor_cmd_engine`

## Requirements
- R1: The writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555 make the next write a program. After that write, the addressed byte holds its old value ANDed with the written data. Unlock addresses are compared on the low min(ADDR_W,15) address bits.
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555 and 0x55@0x2AAA start an erase on the sixth write. A 0x30 at any address sets every byte to 0xFF in the sector chosen by address bits ADDR_W-1 down to SECT_W. A 0x10 at 0x5555 sets the whole array to 0xFF.
- R3: A write whose address or data does not fit the current step of a sequence abandons that sequence and changes no array byte. A new command must start again from the first unlock write.
- R4: A write pulse counts only while chip-enable is low, write-enable is low and output-enable is high. Address and data are taken when write-enable or chip-enable rises first. A pulse made with output-enable low has no effect.
- R5: For PROG_CYCLES cycles after a program starts, a read returns the complement of bit 7 of the programmed data on bit 7. After that time it returns the stored byte.
- R6: While an erase runs, bit 7 of any read is 0. After the erase, the erased bytes read 0xFF.
- R7: While busy, bit 6 takes opposite values on two successive read accesses, and bits 5 to 0 read 0.
- R8: The writes 0xAA@0x5555, 0x55@0x2AAA and 0x90@0x5555 enter identification mode. In that mode address 0 reads 0xBF, address 1 reads 0xD4 plus SIZE_SEL, and other addresses read 0x00. The same sequence ending in 0xF0 returns to array reads.
- R9: Every write that completes while an operation is busy is ignored, the identification exit included. A write that completes in the last busy cycle is dropped, and one that completes a cycle later is accepted.
- R10: dataOe is high exactly when chip-enable and output-enable are low and write-enable is high. Otherwise dataOut is 0x00.
- R11: After reset the block is not busy, not in identification mode, and accepts a command at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, ID byte or status |
| dataOe | output | 1 | High while a read access drives dataOut |

## Verification
The case that needs care is a write pulse that finishes in the same cycle as the busy timer reaches its last count. The command decoder and the timer both act at that edge, and the write must lose. The bench starts a program and waits a known number of negative edges. It then issues a new program sequence whose first write ends exactly on the final busy cycle, and a second one that ends one cycle later. The first must leave its target at 0xFF and the second must store its data. Reads of the status bits that overlap program and erase are judged the same way, against values the bench derives from the written byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  // Steps of the unlock walk
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_U1,
    SEQ_U2,
    SEQ_E3,
    SEQ_E4,
    SEQ_E5,
    SEQ_PROG
  } seqState_t;

  typedef enum logic [1:0] {
    OP_PROG,
    OP_SECT,
    OP_CHIP
  } opKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic progWe;     // program the latched byte this cycle
    logic eraseWe;    // write 0xFF at the sweep address this cycle
    logic busy;       // internal operation running
    logic busyErase;  // running operation is an erase
    logic idMode;     // identification mode active
    logic toggle;     // alternating status bit
  } ctrlStrobe_t;

  localparam logic [14:0] UNLK_ADDR_A = 15'h5555;
  localparam logic [14:0] UNLK_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLK_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_SECT    = 8'h30;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_ID_IN   = 8'h90;
  localparam logic [7:0]  CMD_ID_OUT  = 8'hF0;
  localparam logic [7:0]  MAKER_CODE  = 8'hBF;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SECT_W      = 9,
  parameter int PROG_CYCLES = 20,
  parameter int SECT_CYCLES = 600,
  parameter int CHIP_CYCLES = 2100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output ctrlStrobe_t       ctl,
  output logic [ADDR_W-1:0] latAddr,
  output logic [7:0]        latData,
  output logic [ADDR_W-1:0] eraseAddr,
  output logic              readAct
);

  localparam int SECT_BYTES  = 1 << SECT_W;
  localparam int ARRAY_BYTES = 1 << ADDR_W;
  localparam int EFF_PROG    = (PROG_CYCLES > 1) ? PROG_CYCLES : 2;
  localparam int EFF_SECT    = (SECT_CYCLES > SECT_BYTES) ? SECT_CYCLES : SECT_BYTES;
  localparam int EFF_CHIP    = (CHIP_CYCLES > ARRAY_BYTES) ? CHIP_CYCLES : ARRAY_BYTES;
  localparam int MAX_A       = (EFF_PROG > EFF_SECT) ? EFF_PROG : EFF_SECT;
  localparam int MAX_C       = (MAX_A > EFF_CHIP) ? MAX_A : EFF_CHIP;
  localparam int CNT_W       = $clog2(MAX_C + 1);
  localparam int UA_W        = (ADDR_W < 15) ? ADDR_W : 15;
  localparam int BASE_W      = ADDR_W - SECT_W;

  // Pin front end
  logic writeAct, wrActQ, rdActQ, wrStrobe, accept;
  assign writeAct = !ceN && !weN && oeN;
  assign readAct  = !ceN && !oeN && weN;
  // pulse ends when either enable rises; output-enable low cancels it
  assign wrStrobe = wrActQ && !writeAct && oeN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrActQ  <= 1'b0;
      rdActQ  <= 1'b0;
      latAddr <= '0;
      latData <= '0;
    end else begin
      wrActQ <= writeAct;
      rdActQ <= readAct;
      if (writeAct) begin
        latAddr <= addr;
        latData <= dataIn;
      end
    end
  end

  // Busy timer state
  logic              busyQ;
  opKind_t           opQ;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lastCnt;
  logic [CNT_W-1:0]  sweepLen;
  logic [BASE_W-1:0] sectBase;
  logic              toggleQ;

  assign accept = wrStrobe && !busyQ;

  // Command walk
  seqState_t seq, seqNext;
  logic      idMode, idNext;
  logic      startProg, startSect, startChip;
  logic      isA, isB;

  assign isA = (latAddr[UA_W-1:0] == UNLK_ADDR_A[UA_W-1:0]);
  assign isB = (latAddr[UA_W-1:0] == UNLK_ADDR_B[UA_W-1:0]);

  always_comb begin
    seqNext   = seq;
    idNext    = idMode;
    startProg = 1'b0;
    startSect = 1'b0;
    startChip = 1'b0;
    if (accept) begin
      case (seq)
        SEQ_IDLE: seqNext = (isA && latData == UNLK_DATA_A) ? SEQ_U1 : SEQ_IDLE;
        SEQ_U1:   seqNext = (isB && latData == UNLK_DATA_B) ? SEQ_U2 : SEQ_IDLE;
        SEQ_U2: begin
          seqNext = SEQ_IDLE;
          if (isA) begin
            case (latData)
              CMD_PROG:   seqNext = SEQ_PROG;
              CMD_ERASE:  seqNext = SEQ_E3;
              CMD_ID_IN:  idNext  = 1'b1;
              CMD_ID_OUT: idNext  = 1'b0;
              default:    seqNext = SEQ_IDLE;
            endcase
          end
        end
        SEQ_E3:   seqNext = (isA && latData == UNLK_DATA_A) ? SEQ_E4 : SEQ_IDLE;
        SEQ_E4:   seqNext = (isB && latData == UNLK_DATA_B) ? SEQ_E5 : SEQ_IDLE;
        SEQ_E5: begin
          seqNext = SEQ_IDLE;
          if (latData == CMD_SECT)             startSect = 1'b1;
          else if (isA && latData == CMD_CHIP) startChip = 1'b1;
        end
        SEQ_PROG: begin
          seqNext   = SEQ_IDLE;
          startProg = 1'b1;
        end
        default:  seqNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seq    <= SEQ_IDLE;
      idMode <= 1'b0;
    end else begin
      seq    <= seqNext;
      idMode <= idNext;
    end
  end

  // Busy timer and erase sweep
  always_comb begin
    case (opQ)
      OP_SECT: begin
        lastCnt  = CNT_W'(EFF_SECT - 1);
        sweepLen = CNT_W'(SECT_BYTES);
      end
      OP_CHIP: begin
        lastCnt  = CNT_W'(EFF_CHIP - 1);
        sweepLen = CNT_W'(ARRAY_BYTES);
      end
      default: begin
        lastCnt  = CNT_W'(EFF_PROG - 1);
        sweepLen = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      opQ      <= OP_PROG;
      cnt      <= '0;
      sectBase <= '0;
      toggleQ  <= 1'b0;
    end else begin
      if (startProg || startSect || startChip) begin
        busyQ <= 1'b1;
        cnt   <= '0;
        opQ   <= startProg ? OP_PROG : (startSect ? OP_SECT : OP_CHIP);
        if (startSect) sectBase <= latAddr[ADDR_W-1:SECT_W];
      end else if (busyQ) begin
        if (cnt == lastCnt) busyQ <= 1'b0;
        cnt <= cnt + 1'b1;
      end
      if (readAct && !rdActQ && busyQ) toggleQ <= ~toggleQ;
    end
  end

  assign eraseAddr = (opQ == OP_CHIP) ? cnt[ADDR_W-1:0]
                                      : {sectBase, cnt[SECT_W-1:0]};

  assign ctl.progWe    = startProg;
  assign ctl.eraseWe   = busyQ && (opQ != OP_PROG) && (cnt < sweepLen);
  assign ctl.busy      = busyQ;
  assign ctl.busyErase = (opQ != OP_PROG);
  assign ctl.idMode    = idMode;
  assign ctl.toggle    = toggleQ;

endmodule

// File: rtl/flash_array_dp.sv
module flash_array_dp
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 11,
  parameter logic [7:0]  DEV_CODE = 8'hD7
) (
  input  logic              clk,
  input  ctrlStrobe_t       ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] latAddr,
  input  logic [7:0]        latData,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  logic              readAct,
  output logic [7:0]        dataOut
);

  localparam int ARRAY_BYTES = 1 << ADDR_W;

  logic [7:0] mem [ARRAY_BYTES];
  logic [7:0] rdQ;
  logic       progBit7;

  always_ff @(posedge clk) begin
    if (ctl.progWe)       mem[latAddr]   <= mem[latAddr] & latData;
    else if (ctl.eraseWe) mem[eraseAddr] <= 8'hFF;
    if (ctl.progWe) progBit7 <= latData[7];
    rdQ <= mem[addr];
  end

  always_comb begin
    if (!readAct)
      dataOut = 8'h00;
    else if (ctl.busy)
      dataOut = {(ctl.busyErase ? 1'b0 : ~progBit7), ctl.toggle, 6'b0};
    else if (ctl.idMode)
      dataOut = (addr == '0) ? MAKER_CODE :
                (addr == ADDR_W'(1)) ? DEV_CODE : 8'h00;
    else
      dataOut = rdQ;
  end

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SECT_W      = 9,
  parameter int PROG_CYCLES = 20,
  parameter int SECT_CYCLES = 600,
  parameter int CHIP_CYCLES = 2100,
  parameter int SIZE_SEL    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  localparam logic [7:0] DEV_CODE = 8'hD4 + 8'(SIZE_SEL % 4);

  ctrlStrobe_t       ctl;
  logic [ADDR_W-1:0] latAddr;
  logic [ADDR_W-1:0] eraseAddr;
  logic [7:0]        latData;
  logic              readAct;

  flash_cmd_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYCLES(PROG_CYCLES),
    .SECT_CYCLES(SECT_CYCLES), .CHIP_CYCLES(CHIP_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .ctl(ctl), .latAddr(latAddr),
    .latData(latData), .eraseAddr(eraseAddr), .readAct(readAct)
  );

  flash_array_dp #(
    .ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)
  ) dp_i (
    .clk(clk), .ctl(ctl), .addr(addr), .latAddr(latAddr),
    .latData(latData), .eraseAddr(eraseAddr), .readAct(readAct),
    .dataOut(dataOut)
  );

  assign dataOe = readAct;

endmodule

// File: rtl/nor_cmd_engine_chk.sv
module nor_cmd_engine_chk
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dataOut,
  input logic              dataOe,
  input ctrlStrobe_t       ctl
);

  // R5
  prog_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.progWe |=> (ctl.busy && !ctl.progWe));

  // R6
  erase_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && ctl.busyErase && dataOe) |-> !dataOut[7]);

  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.busy) |-> $stable(ctl.idMode));

  // R10
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == 8'h00));

  // R8
  maker_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.idMode && !ctl.busy && dataOe && addr == '0) |-> (dataOut == MAKER_CODE));

  // R7
  status_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && dataOe) |-> (dataOut[5:0] == 6'b0));

endmodule

bind nor_cmd_engine nor_cmd_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .addr(addr), .dataOut(dataOut),
  .dataOe(dataOe), .ctl(ctl)
);

// File: tb/nor_cmd_engine_tb_top.sv
module nor_cmd_engine_tb_top;

  localparam int ADDR_W   = 11;
  localparam int SECT_W   = 9;
  localparam int PROG_C   = 20;
  localparam int SECT_C   = 600;
  localparam int CHIP_C   = 2100;
  localparam int SIZE_SEL = 2;
  localparam int NBYTES   = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] UA = ADDR_W'(15'h5555);
  localparam logic [ADDR_W-1:0] UB = ADDR_W'(15'h2AAA);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        dataIn = '0;
  logic [7:0]        dataOut;
  logic              dataOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [NBYTES];

  nor_cmd_engine #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYCLES(PROG_C),
    .SECT_CYCLES(SECT_C), .CHIP_CYCLES(CHIP_C), .SIZE_SEL(SIZE_SEL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] progResult(logic [7:0] old, logic [7:0] d);
    return old & d;
  endfunction

  function automatic logic [7:0] devCode();
    return 8'hD4 + 8'(SIZE_SEL);
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
  endtask

  task automatic wrOeLow(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic wrCe(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; weN = 1'b0;
    @(negedge clk);
    ceN = 1'b0;
    @(negedge clk);
    ceN = 1'b1;
    @(negedge clk);
    weN = 1'b1;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    v = dataOut;
    oeN = 1'b1; ceN = 1'b1;
  endtask

  task automatic readCheck(string req, logic [ADDR_W-1:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check8(req, v, exp);
  endtask

  task automatic progCmd(logic [ADDR_W-1:0] a, logic [7:0] d);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'hA0); wr(a, d);
  endtask

  task automatic eraseCmd(logic [ADDR_W-1:0] a, logic [7:0] d);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'h80);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(a, d);
  endtask

  task automatic idCmd(logic [7:0] c);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, c);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic progAndModel(logic [ADDR_W-1:0] a, logic [7:0] d);
    progCmd(a, d);
    idle(PROG_C + 4);
    model[a] = progResult(model[a], d);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v1, v2;
    void'($urandom(32'h5EED1234));
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R10 / R11: quiet bus after reset
    check8("R10 reset dataOe", {7'b0, dataOe}, 8'h00);
    check8("R10 reset dataOut", dataOut, 8'h00);

    // R2 / R6 / R7: chip erase right after reset (R11 accepted at once)
    eraseCmd(UA, 8'h10);
    rd(ADDR_W'(3), v1);
    check8("R6 chip erase busy bit7", {7'b0, v1[7]}, 8'h00);
    rd(ADDR_W'(3), v2);
    check8("R7 toggle alternates", {7'b0, v1[6] ^ v2[6]}, 8'h01);
    check8("R7 low bits zero", {2'b0, v2[5:0]}, 8'h00);
    idle(CHIP_C + 5);
    for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;
    readCheck("R11 idle after reset, no id mode", ADDR_W'(0), 8'hFF);
    readCheck("R2 chip erase last byte", ADDR_W'(NBYTES - 1), 8'hFF);

    // R1 / R5 program and AND behaviour
    progCmd(ADDR_W'(11'h123), 8'h5A);
    rd(ADDR_W'(11'h123), v1);
    check8("R5 program busy bit7", {7'b0, v1[7]}, 8'h01);
    idle(PROG_C + 4);
    model[11'h123] = 8'h5A;
    readCheck("R5 true data after program", ADDR_W'(11'h123), 8'h5A);
    progAndModel(ADDR_W'(11'h123), 8'h0F);
    readCheck("R1 program ANDs old data", ADDR_W'(11'h123), progResult(8'h5A, 8'h0F));

    // R3 invalid command byte and invalid address
    idCmd(8'h77);
    wr(ADDR_W'(11'h200), 8'h00);
    idle(PROG_C + 4);
    readCheck("R3 bad command byte", ADDR_W'(11'h200), 8'hFF);
    wr(UA, 8'hAA); wr(ADDR_W'(11'h234), 8'h55); wr(UA, 8'hA0); wr(ADDR_W'(11'h201), 8'h00);
    idle(PROG_C + 4);
    readCheck("R3 bad unlock address", ADDR_W'(11'h201), 8'hFF);

    // R4 inhibited first byte with output-enable low
    wrOeLow(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'hA0); wr(ADDR_W'(11'h202), 8'h00);
    idle(PROG_C + 4);
    readCheck("R4 OE low inhibits write", ADDR_W'(11'h202), 8'hFF);
    // R4 chip-enable controlled pulses
    wrCe(UA, 8'hAA); wrCe(UB, 8'h55); wrCe(UA, 8'hA0); wrCe(ADDR_W'(11'h203), 8'h3C);
    idle(PROG_C + 4);
    model[11'h203] = 8'h3C;
    readCheck("R4 CE rising latches", ADDR_W'(11'h203), 8'h3C);

    // R8 identification mode
    idCmd(8'h90);
    readCheck("R8 maker code", ADDR_W'(0), 8'hBF);
    readCheck("R8 device code", ADDR_W'(1), devCode());
    readCheck("R8 other address", ADDR_W'(5), 8'h00);
    idCmd(8'hF0);
    readCheck("R8 exit returns array", ADDR_W'(11'h123), model[11'h123]);

    // R9 id exit ignored while busy
    idCmd(8'h90);
    progCmd(ADDR_W'(11'h300), 8'h3C);
    idCmd(8'hF0);
    idle(PROG_C + 4);
    model[11'h300] = 8'h3C;
    readCheck("R9 id exit ignored while busy", ADDR_W'(0), 8'hBF);
    idCmd(8'hF0);
    readCheck("R9 program in id mode", ADDR_W'(11'h300), 8'h3C);

    // R9 boundary: write ending in last busy cycle is dropped
    progCmd(ADDR_W'(11'h310), 8'hF0);
    idle(PROG_C - 2);
    progCmd(ADDR_W'(11'h311), 8'h11);
    idle(PROG_C + 4);
    model[11'h310] = 8'hF0;
    readCheck("R9 write in last busy cycle dropped", ADDR_W'(11'h311), 8'hFF);
    progCmd(ADDR_W'(11'h320), 8'h0F);
    idle(PROG_C - 1);
    progCmd(ADDR_W'(11'h321), 8'h22);
    idle(PROG_C + 4);
    model[11'h320] = 8'h0F;
    model[11'h321] = 8'h22;
    readCheck("R9 write one cycle later accepted", ADDR_W'(11'h321), 8'h22);

    // R2 sector erase bounded by sector
    progAndModel(ADDR_W'(11'h3FF), 8'h00);
    progAndModel(ADDR_W'(11'h400), 8'h00);
    progAndModel(ADDR_W'(11'h5FF), 8'h00);
    progAndModel(ADDR_W'(11'h600), 8'h00);
    eraseCmd(ADDR_W'(11'h4AB), 8'h30);
    rd(ADDR_W'(11'h400), v1);
    check8("R6 sector erase busy bit7", {7'b0, v1[7]}, 8'h00);
    idle(SECT_C + 5);
    for (int i = 11'h400; i < 11'h600; i++) model[i] = 8'hFF;
    readCheck("R2 sector start erased", ADDR_W'(11'h400), 8'hFF);
    readCheck("R2 sector end erased", ADDR_W'(11'h5FF), 8'hFF);
    readCheck("R2 below sector kept", ADDR_W'(11'h3FF), 8'h00);
    readCheck("R2 above sector kept", ADDR_W'(11'h600), 8'h00);

    // R1 / R5 / R7 constrained random programs
    for (int k = 0; k < 30; k++) begin
      logic [ADDR_W-1:0] a;
      logic [7:0] d;
      a = ADDR_W'($urandom_range(0, NBYTES - 1));
      d = 8'($urandom);
      progCmd(a, d);
      rd(a, v1);
      check8("R5 random busy bit7", {7'b0, v1[7]}, {7'b0, ~d[7]});
      check8("R7 random status low bits", {2'b0, v1[5:0]}, 8'h00);
      idle(PROG_C + 2);
      model[a] = progResult(model[a], d);
      readCheck("R1 random program", a, model[a]);
    end
    for (int k = 0; k < 30; k++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom_range(0, NBYTES - 1));
      readCheck("R1 random readback", a, model[a]);
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule